// File: doc/BRIEF.md
# Cascadable 8/16-bit Timer/Counter

The block holds two 8-bit up-counters, a low channel and a high channel. In split mode each channel runs from its own clock select and compare value, and clears itself when its count equals its compare value on a counting tick. In cascade mode the two channels act as one 16-bit counter. The high byte advances only when the low byte wraps, and a match needs the whole 16-bit count to equal the pair of compare values. The low channel, and the 16-bit counter, can count rising edges of an external event input instead of an internal clock. The same matches also drive a square-wave output.

Each channel has a run input. The cascade bit is latched only while both channels are stopped, so a counter that is running never changes its mode partway through. Each channel has a sticky match flag, which a clear input removes. The count is brought out so that it can be read back.

Top module: `cascade_timer`

## Requirements
- R1: After reset the count output is 0, the square-wave output is 0, both match flags are 0 and split mode is in force.
- R2: In split mode a running channel changes state on each of its ticks. If its count equals its compare value it goes to 0 and signals a match. Otherwise it increments by one. A compare value C therefore gives a period of C+1 ticks.
- R3: Clock select codes are 0 = every clock, 1 = one tick per 4 clocks and 2 = one tick per 16 clocks. A free-running prescaler counts clocks from reset. Code 1 ticks on the clocks where the prescaler's low 2 bits are all ones, and code 2 ticks where its low 4 bits are all ones. Each channel decodes its own select.
- R4: Select code 3 counts rising edges of the event input, resynchronised by two flip-flops. The count changes on the third rising clock edge after the input rises. Code 3 works for the low channel and for the 16-bit counter. In split mode it stops the high channel.
- R5: The square-wave output toggles on every low-channel match in split mode and on every 16-bit match in cascade mode. High-channel matches in split mode leave it unchanged.
- R6: A match sets that channel's flag. The flag stays set until its clear input is high at a clock edge with no new match. A match in the same cycle as a clear leaves the flag set.
- R7: In cascade mode the counter is {high, low}. It runs under the low channel's run input and clock select. The high byte increments when the low byte steps from 0xFF to 0x00. A 16-bit match clears both bytes and sets only the low channel's flag.
- R8: The cascade input is taken into the mode only at clock edges where both run inputs are low. While either run input is high, changes to it have no effect on counting.
- R9: A channel whose run input is low (in cascade mode, the low run input) holds its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run0_i | input | 1 | Run enable, low channel / 16-bit counter |
| run1_i | input | 1 | Run enable, high channel |
| sel0_i | input | 2 | Clock select, low channel / 16-bit counter |
| sel1_i | input | 2 | Clock select, high channel |
| cmp0_i | input | 8 | Compare value, low channel (low byte in cascade) |
| cmp1_i | input | 8 | Compare value, high channel (high byte in cascade) |
| cascade_i | input | 1 | Requested mode: 1 = one 16-bit counter |
| evt_i | input | 1 | External event input |
| sqw_o | output | 1 | Square-wave output |
| irq0_o | output | 1 | Low channel / 16-bit match flag |
| irq1_o | output | 1 | High channel match flag |
| irq_clr0_i | input | 1 | Clears irq0_o |
| irq_clr1_i | input | 1 | Clears irq1_o |
| cnt_o | output | 16 | {high count, low count} |

## Verification
The bench drives the 16-bit counter across a low-byte wrap to a match of 0x0105. A carry taken on the wrong edge, or a match on the low byte alone, would clear it early or let it run past. It flips the cascade input while the counter is running; a design that latches the mode freely would fall back to split counting in the middle of a period. Event pulses are counted through the synchroniser with exact latency, and a high channel set to code 3 must stay frozen. A compare value of zero, with the clear held high, checks that a match wins over a clear; a design with the opposite priority would drop the flag.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    SEL_FAST  = 2'd0,
    SEL_DIV_A = 2'd1,
    SEL_DIV_B = 2'd2,
    SEL_EXT   = 2'd3
  } clk_sel_e;
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int DIV_A_LOG = 2,
  parameter int DIV_B_LOG = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  output logic tick_a_o,
  output logic tick_b_o,
  output logic evt_pulse_o
);
  localparam int PRE_W = (DIV_B_LOG > DIV_A_LOG) ? DIV_B_LOG : DIV_A_LOG;

  logic [PRE_W-1:0] pre_q;
  logic [2:0]       sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      sync_q <= '0;
    end else begin
      pre_q  <= pre_q + 1'b1;
      sync_q <= {sync_q[1:0], evt_i};
    end
  end

  assign tick_a_o    = &pre_q[DIV_A_LOG-1:0];
  assign tick_b_o    = &pre_q[DIV_B_LOG-1:0];
  // sync_q[1] is the second stage, sync_q[2] the edge history
  assign evt_pulse_o = sync_q[1] & ~sync_q[2];
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         clr_i,
  input  logic [W-1:0] cmp_i,
  output logic [W-1:0] cnt_o,
  output logic         eq_o,
  output logic         full_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign eq_o   = (cnt_q == cmp_i);
  assign full_o = &cnt_q;
endmodule

// File: rtl/cascade_timer.sv
module cascade_timer #(
  parameter int W         = 8,
  parameter int DIV_A_LOG = 2,
  parameter int DIV_B_LOG = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run0_i,
  input  logic           run1_i,
  input  logic [1:0]     sel0_i,
  input  logic [1:0]     sel1_i,
  input  logic [W-1:0]   cmp0_i,
  input  logic [W-1:0]   cmp1_i,
  input  logic           cascade_i,
  input  logic           evt_i,
  output logic           sqw_o,
  output logic           irq0_o,
  output logic           irq1_o,
  input  logic           irq_clr0_i,
  input  logic           irq_clr1_i,
  output logic [2*W-1:0] cnt_o
);
  import tmr_pkg::*;

  localparam int NCH = 2;

  logic tick_a, tick_b, evt_pulse;
  logic mode_q;
  logic sqw_hit;

  logic [1:0]   sel [NCH];
  logic [W-1:0] cmp [NCH];
  logic [W-1:0] cnt [NCH];
  logic [NCH-1:0] tick, inc, clr, eq, full, hit;

  assign sel[0] = sel0_i;
  assign sel[1] = sel1_i;
  assign cmp[0] = cmp0_i;
  assign cmp[1] = cmp1_i;

  tmr_tick_gen #(.DIV_A_LOG(DIV_A_LOG), .DIV_B_LOG(DIV_B_LOG)) u_tick (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_i       (evt_i),
    .tick_a_o    (tick_a),
    .tick_b_o    (tick_b),
    .evt_pulse_o (evt_pulse)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam bit EXT_OK = (i == 0);

    always_comb begin
      unique case (clk_sel_e'(sel[i]))
        SEL_FAST:  tick[i] = 1'b1;
        SEL_DIV_A: tick[i] = tick_a;
        SEL_DIV_B: tick[i] = tick_b;
        default:   tick[i] = EXT_OK ? evt_pulse : 1'b0;
      endcase
    end

    tmr_chan #(.W(W)) u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (inc[i]),
      .clr_i  (clr[i]),
      .cmp_i  (cmp[i]),
      .cnt_o  (cnt[i]),
      .eq_o   (eq[i]),
      .full_o (full[i])
    );
  end

  // 16-bit match needs both bytes; high byte steps on low-byte wrap
  always_comb begin
    if (mode_q) begin
      inc[0] = run0_i & tick[0];
      hit[0] = inc[0] & eq[0] & eq[1];
      hit[1] = 1'b0;
      inc[1] = inc[0] & full[0] & ~hit[0];
      clr[0] = hit[0];
      clr[1] = hit[0];
    end else begin
      inc[0] = run0_i & tick[0];
      inc[1] = run1_i & tick[1];
      hit[0] = inc[0] & eq[0];
      hit[1] = inc[1] & eq[1];
      clr[0] = hit[0];
      clr[1] = hit[1];
    end
  end

  assign sqw_hit = hit[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      sqw_o  <= 1'b0;
      irq0_o <= 1'b0;
      irq1_o <= 1'b0;
    end else begin
      if (!run0_i && !run1_i) mode_q <= cascade_i;
      if (sqw_hit) sqw_o <= ~sqw_o;
      if (hit[0])          irq0_o <= 1'b1;
      else if (irq_clr0_i) irq0_o <= 1'b0;
      if (hit[1])          irq1_o <= 1'b1;
      else if (irq_clr1_i) irq1_o <= 1'b0;
    end
  end

  assign cnt_o = {cnt[1], cnt[0]};
endmodule

// File: rtl/cascade_timer_chk.sv
module cascade_timer_chk #(
  parameter int W = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           run0_i,
  input logic           run1_i,
  input logic           irq0_o,
  input logic           irq1_o,
  input logic           irq_clr0_i,
  input logic           irq_clr1_i,
  input logic           sqw_o,
  input logic [2*W-1:0] cnt_o,
  input logic           mode_q,
  input logic           sqw_hit
);
  // R8
  mode_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run0_i || run1_i) |=> $stable(mode_q));

  // R9
  stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run0_i && !run1_i) |=> $stable(cnt_o));

  // R5
  sqw_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sqw_o) |-> $past(sqw_hit));

  // R6
  irq0_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq0_o && !irq_clr0_i) |=> irq0_o);

  // R6
  irq1_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq1_o && !irq_clr1_i) |=> irq1_o);

  // R7
  carry_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(cnt_o[2*W-1:W]) && $past(mode_q)) |->
      (($past(cnt_o[W-1:0]) == {W{1'b1}}) || (cnt_o == '0)));
endmodule

bind cascade_timer cascade_timer_chk #(.W(W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .run0_i     (run0_i),
  .run1_i     (run1_i),
  .irq0_o     (irq0_o),
  .irq1_o     (irq1_o),
  .irq_clr0_i (irq_clr0_i),
  .irq_clr1_i (irq_clr1_i),
  .sqw_o      (sqw_o),
  .cnt_o      (cnt_o),
  .mode_q     (mode_q),
  .sqw_hit    (sqw_hit)
);

// File: tb/cascade_timer_bench.sv
module cascade_timer_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        run0_i = 0, run1_i = 0;
  logic [1:0]  sel0_i = 0, sel1_i = 0;
  logic [7:0]  cmp0_i = 0, cmp1_i = 0;
  logic        cascade_i = 0, evt_i = 0;
  logic        irq_clr0_i = 0, irq_clr1_i = 0;
  logic        sqw_o, irq0_o, irq1_o;
  logic [15:0] cnt_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  string req = "R1";

  // reference state
  int m_pre = 0, c0 = 0, c1 = 0;
  bit s1 = 0, s2 = 0, s3 = 0, mq = 0, msq = 0, mi0 = 0, mi1 = 0;

  always #10 clk_i = ~clk_i;

  cascade_timer u_cascade_timer (.*);

  function automatic bit sel_tick(input logic [1:0] s, input bit ext_ok);
    case (s)
      2'd0: return 1;
      2'd1: return (m_pre % 4) == 3;
      2'd2: return m_pre == 15;
      default: return ext_ok && s2 && !s3;
    endcase
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_pre = 0; c0 = 0; c1 = 0; s1 = 0; s2 = 0; s3 = 0;
      mq = 0; msq = 0; mi0 = 0; mi1 = 0;
    end else begin
      bit t0, t1, i0, i1, h0, h1;
      int n0, n1;
      t0 = sel_tick(sel0_i, 1);
      t1 = sel_tick(sel1_i, 0);
      n0 = c0; n1 = c1; h0 = 0; h1 = 0;
      i0 = run0_i && t0;
      if (mq) begin
        if (i0 && c0 == cmp0_i && c1 == cmp1_i) begin h0 = 1; n0 = 0; n1 = 0; end
        else if (i0) begin n0 = (c0 + 1) % 256; if (c0 == 255) n1 = (c1 + 1) % 256; end
      end else begin
        i1 = run1_i && t1;
        if (i0) begin if (c0 == cmp0_i) begin h0 = 1; n0 = 0; end else n0 = c0 + 1; end
        if (i1) begin if (c1 == cmp1_i) begin h1 = 1; n1 = 0; end else n1 = c1 + 1; end
      end
      if (h0) msq = !msq;
      mi0 = h0 ? 1 : (irq_clr0_i ? 0 : mi0);
      mi1 = h1 ? 1 : (irq_clr1_i ? 0 : mi1);
      if (!run0_i && !run1_i) mq = cascade_i;
      c0 = n0; c1 = n1;
      m_pre = (m_pre + 1) % 16;
      s3 = s2; s2 = s1; s1 = evt_i;
    end
  end

  task automatic check_all();
    n_chk++;
    if (cnt_o !== 16'((c1 << 8) | c0)) begin
      n_bad++; $display("FAIL %s cnt_o got %h exp %h", req, cnt_o, 16'((c1 << 8) | c0));
    end
    n_chk++;
    if (sqw_o !== msq) begin n_bad++; $display("FAIL %s sqw_o got %b exp %b", req, sqw_o, msq); end
    n_chk++;
    if (irq0_o !== mi0) begin n_bad++; $display("FAIL %s irq0_o got %b exp %b", req, irq0_o, mi0); end
    n_chk++;
    if (irq1_o !== mi1) begin n_bad++; $display("FAIL %s irq1_o got %b exp %b", req, irq1_o, mi1); end
  endtask

  task automatic run(input int n, input bit toggle_evt);
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i);
      check_all();
      if (toggle_evt) evt_i = (k % 7) < 3;
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    req = "R1"; check_all();
    rst_ni = 1;
    run(3, 0);
    // R2 R3: independent clocks, split mode
    req = "R2/R3";
    cmp0_i = 8'd5; cmp1_i = 8'd3; sel0_i = 2'd0; sel1_i = 2'd1;
    run0_i = 1; run1_i = 1;
    run(60, 0);
    req = "R3"; sel0_i = 2'd2; sel1_i = 2'd0; cmp0_i = 8'd2;
    run(80, 0);
    // R6 clear
    req = "R6"; irq_clr0_i = 1; irq_clr1_i = 1; run(2, 0);
    irq_clr0_i = 0; irq_clr1_i = 0;
    // R4: event counting low channel, high channel on code 3 frozen
    req = "R4"; sel0_i = 2'd3; sel1_i = 2'd3; cmp0_i = 8'd4;
    run(90, 1);
    evt_i = 0;
    // R9: stop holds, then switch to cascade
    req = "R9"; run0_i = 0; run1_i = 0; run(5, 0);
    req = "R8"; cascade_i = 1; run(2, 0);
    // R7: 16-bit across wrap to match 0x0105
    req = "R7"; sel0_i = 2'd0; cmp0_i = 8'h05; cmp1_i = 8'h01; run0_i = 1;
    run(300, 0);
    // R8: mode request dropped while running has no effect
    req = "R8"; cascade_i = 0; run(300, 0);
    run0_i = 0; run(3, 0);
    // R7 R4: cascade with events (mode stays split now), go back to cascade
    cascade_i = 1; run(2, 0);
    req = "R4/R7"; sel0_i = 2'd3; cmp0_i = 8'd3; cmp1_i = 8'd0; run0_i = 1;
    run(120, 1);
    evt_i = 0;
    run0_i = 0; cascade_i = 0; run(3, 0);
    // R6 R5: compare zero, match every tick, clear held (set wins)
    req = "R6/R5"; cmp0_i = 8'd0; cmp1_i = 8'd0; sel0_i = 2'd0; sel1_i = 2'd2;
    run0_i = 1; run1_i = 1; irq_clr0_i = 1; irq_clr1_i = 1;
    run(40, 0);
    irq_clr0_i = 0; irq_clr1_i = 0;
    finish_up();
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, got timeout exp completion");
    finish_up();
  end
endmodule